// File: doc/BRIEF.md
# Selectable Binary Clock Divider with Output Enable

This block takes a free-running oscillator clock and produces a divided clock at 1, 2, 4, 8, 16 or 32 times its period. The ratio is chosen by two select inputs. One has three levels: low, high and floating. The other has two levels, and a floating value on it counts as low. Every external level is carried as a 2-bit code. The output can be released to high impedance through either of two enables, one active low and one active high. The pad is modelled as a data bit plus a drive-enable bit.

Whenever the output is taken off the line, the divider is parked. When the output returns, the first half-period it delivers is a full-length HIGH phase. A new ratio is never applied in the middle of a cycle. It is loaded at the next rising edge of the divided clock, so no runt pulse appears. In divide-by-1 mode the input clock is passed straight through.

Top module: `bindiv_gen`

## Requirements
- R1: With the two-level select low (code 00) or floating (code 10 or 11), the three-level select picks the ratio: floating (code 10) gives 1, high (code 01) gives 2, and low (code 00) gives 4.
- R2: With the two-level select high (code 01), the three-level select picks the ratio: floating gives 8, high gives 16, and low gives 32.
- R3: Code 11 on the three-level select acts exactly like floating (10). Code 10 or 11 on the two-level select acts exactly like low (00).
- R4: The active-low enable turns the drive-enable output off when its code is high (01). With code low (00) or floating (10, 11), it leaves the output driven.
- R5: The active-high enable turns the drive-enable output off when its code is low (00). With code high (01) or floating (10, 11), it leaves the output driven. The drive-enable output is the AND of both enables and responds combinationally.
- R6: While either enable is off, the data output is HIGH. After both enables come back, the first rising clock edge starts a HIGH phase that lasts exactly N/2 input clock cycles for a ratio N of 2 or more.
- R7: For a ratio N of 2 or more, the output changes only at rising input clock edges. It stays HIGH for N/2 cycles and then LOW for N/2 cycles.
- R8: A ratio change made while dividing by 2 or more takes effect only at the next rising edge of the divided output. Every half-period up to that edge keeps the old length.
- R9: With divide-by-1 applied, the data output equals the input clock.
- R10: While the asynchronous active-low reset is asserted, and until the first rising clock edge after it is released, the data output is HIGH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Oscillator clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_tri | input | 2 | Three-level ratio select (00 low, 01 high, 1x floating) |
| sel_bin | input | 2 | Two-level ratio select (01 high, else low) |
| oe_lo | input | 2 | Active-low output enable, level code |
| oe_hi | input | 2 | Active-high output enable, level code |
| clk_out | output | 1 | Divided clock data value |
| clk_out_en | output | 1 | Drive enable for the output pad (0 = high impedance) |

## Verification
The hardest situation to reach from the ports is a ratio change that lands partway through a HIGH phase. It must be followed by a LOW phase of the old length and only then by the new length. A directed sequence starts divide-by-8 from a clean restart, counts two HIGH cycles and switches to divide-by-32, then measures the following phases. Random stimulus also changes the selects and enables at arbitrary phases for thousands of cycles. A bench model of the ratio, phase and restart rules is compared against both outputs every cycle.

// File: rtl/bindiv_pkg.sv
package bindiv_pkg;
    // log2 of the largest divide ratio
    parameter int MAX_LOG2 = 5;
    localparam int SHIFT_W = $clog2(MAX_LOG2 + 1);
    localparam int CNT_W   = (MAX_LOG2 > 1) ? MAX_LOG2 - 1 : 1;

    // 2-bit pin level codes
    localparam logic [1:0] LVL_LOW  = 2'b00;
    localparam logic [1:0] LVL_HIGH = 2'b01;

    typedef logic [SHIFT_W-1:0] shift_t;

    typedef struct packed {
        logic               armed;
        shift_t             shift;
        logic [CNT_W-1:0]   cnt;
        logic               phase;
    } div_state_t;
endpackage

// File: rtl/ratio_decode.sv
module ratio_decode
    import bindiv_pkg::*;
(
    input  logic [1:0] sel_tri,
    input  logic [1:0] sel_bin,
    output shift_t     shift
);
    logic upper_set;

    always_comb begin
        upper_set = (sel_bin == LVL_HIGH);
        unique case (sel_tri)
            LVL_LOW:  shift = upper_set ? shift_t'(5) : shift_t'(2);
            LVL_HIGH: shift = upper_set ? shift_t'(4) : shift_t'(1);
            default:  shift = upper_set ? shift_t'(3) : shift_t'(0);
        endcase
    end
endmodule

// File: rtl/level_enable.sv
module level_enable
    import bindiv_pkg::*;
#(
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input  logic [1:0] code,
    output logic       on
);
    generate
        if (ACTIVE_HIGH) begin : g_act_high
            // floating pulls high: only a driven low disables
            assign on = (code != LVL_LOW);
        end else begin : g_act_low
            // floating pulls low: only a driven high disables
            assign on = (code != LVL_HIGH);
        end
    endgenerate
endmodule

// File: rtl/div_core.sv
module div_core
    import bindiv_pkg::*;
(
    input  logic   clk_in,
    input  logic   rst_n,
    input  logic   enable,
    input  shift_t req_shift,
    output logic   data_out
);
    div_state_t       st_d, st_q;
    logic [CNT_W-1:0] half_m1;
    int unsigned      span;

    always_comb begin
        st_d    = st_q;
        span    = 32'd1 << st_q.shift;
        half_m1 = CNT_W'((span >> 1) - 32'd1);
        if (!enable || !st_q.armed) begin
            // parked: load ratio, restart from HIGH
            st_d.armed = enable;
            st_d.shift = req_shift;
            st_d.cnt   = '0;
            st_d.phase = 1'b1;
        end else if (st_q.shift == '0) begin
            // bypass: every input edge is an output rising edge
            st_d.shift = req_shift;
            st_d.cnt   = '0;
            st_d.phase = 1'b1;
        end else if (st_q.cnt == half_m1) begin
            st_d.cnt   = '0;
            st_d.phase = ~st_q.phase;
            if (!st_q.phase) begin
                st_d.shift = req_shift;
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{armed: 1'b0, shift: '0, cnt: '0, phase: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (!rst_n || !enable || !st_q.armed) begin
            data_out = 1'b1;
        end else if (st_q.shift == '0) begin
            data_out = clk_in;
        end else begin
            data_out = st_q.phase;
        end
    end
endmodule

// File: rtl/bindiv_gen.sv
module bindiv_gen
    import bindiv_pkg::*;
(
    input  logic       clk_in,
    input  logic       rst_n,
    input  logic [1:0] sel_tri,
    input  logic [1:0] sel_bin,
    input  logic [1:0] oe_lo,
    input  logic [1:0] oe_hi,
    output logic       clk_out,
    output logic       clk_out_en
);
    shift_t req_shift;
    logic   on_lo, on_hi, enable;

    ratio_decode u_dec (
        .sel_tri (sel_tri),
        .sel_bin (sel_bin),
        .shift   (req_shift)
    );

    level_enable #(.ACTIVE_HIGH(1'b0)) u_en_lo (.code(oe_lo), .on(on_lo));
    level_enable #(.ACTIVE_HIGH(1'b1)) u_en_hi (.code(oe_hi), .on(on_hi));

    assign enable     = on_lo & on_hi;
    assign clk_out_en = enable;

    div_core u_core (
        .clk_in    (clk_in),
        .rst_n     (rst_n),
        .enable    (enable),
        .req_shift (req_shift),
        .data_out  (clk_out)
    );
endmodule

// File: rtl/bindiv_gen_chk.sv
module bindiv_gen_chk (
    input logic       clk_in,
    input logic       rst_n,
    input logic [1:0] sel_tri,
    input logic [1:0] sel_bin,
    input logic [1:0] oe_lo,
    input logic [1:0] oe_hi,
    input logic       clk_out,
    input logic       clk_out_en
);
    AST_LO_ENABLE_OFF: assert property (@(posedge clk_in) disable iff (!rst_n)
        (oe_lo == 2'b01) |-> !clk_out_en); // R4

    AST_HI_ENABLE_OFF: assert property (@(posedge clk_in) disable iff (!rst_n)
        (oe_hi == 2'b00) |-> !clk_out_en); // R5

    AST_PARKED_HIGH: assert property (@(posedge clk_in) disable iff (!rst_n)
        !clk_out_en |-> clk_out); // R6

    AST_RESTART_HIGH: assert property (@(posedge clk_in) disable iff (!rst_n)
        (clk_out_en && !$past(clk_out_en)) |-> clk_out); // R6

    always_comb begin
        if (!rst_n) begin
            AST_RESET_HIGH: assert (clk_out); // R10
        end
    end
endmodule

bind bindiv_gen bindiv_gen_chk u_chk (.*);

// File: tb/tb_bindiv_gen.sv
`timescale 1ns/1ps
module tb_bindiv_gen;
    logic       clk_in = 1'b0;
    logic       rst_n  = 1'b0;
    logic [1:0] sel_tri = 2'b10;
    logic [1:0] sel_bin = 2'b00;
    logic [1:0] oe_lo   = 2'b00;
    logic [1:0] oe_hi   = 2'b01;
    logic       clk_out, clk_out_en;

    int n_checks = 0;
    int n_errors = 0;

    // bench model state
    bit m_armed = 0;
    int m_shift = 0;
    int m_pos   = 0;
    bit m_phase = 1;

    always #2 clk_in = ~clk_in;

    bindiv_gen dut (
        .clk_in(clk_in), .rst_n(rst_n), .sel_tri(sel_tri), .sel_bin(sel_bin),
        .oe_lo(oe_lo), .oe_hi(oe_hi), .clk_out(clk_out), .clk_out_en(clk_out_en)
    );

    function automatic int want_shift(logic [1:0] t, logic [1:0] b);
        bit up = (b == 2'b01);
        if (t == 2'b00) return up ? 5 : 2;
        if (t == 2'b01) return up ? 4 : 1;
        return up ? 3 : 0;
    endfunction

    function automatic bit want_en(logic [1:0] lo, logic [1:0] hi);
        return (lo != 2'b01) && (hi != 2'b00);
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit en = want_en(oe_lo, oe_hi);
        if (!rst_n) begin
            m_armed = 0; m_pos = 0; m_phase = 1;
        end else if (!en || !m_armed) begin
            m_armed = en; m_shift = want_shift(sel_tri, sel_bin); m_pos = 0; m_phase = 1;
        end else if (m_shift == 0) begin
            m_shift = want_shift(sel_tri, sel_bin); m_pos = 0; m_phase = 1;
        end else begin
            m_pos++;
            if (m_pos == (1 << (m_shift - 1))) begin
                m_pos = 0;
                m_phase = !m_phase;
                if (m_phase) m_shift = want_shift(sel_tri, sel_bin);
            end
        end
    endtask

    // compare at the low phase of the input clock
    task automatic compare();
        bit en  = want_en(oe_lo, oe_hi);
        bit exp = (!rst_n || !en || !m_armed) ? 1'b1 : ((m_shift == 0) ? 1'b0 : m_phase);
        string tag;
        if (!rst_n) tag = "R10";
        else if (!en) tag = "R6";
        else if (m_shift == 0) tag = "R9";
        else tag = "R7";
        check(clk_out_en === en, "R4/R5 enable", int'(clk_out_en), int'(en));
        check(clk_out === exp, tag, int'(clk_out), int'(exp));
    endtask

    task automatic step();
        @(posedge clk_in);
        model_edge();
        @(negedge clk_in);
        #1;
        compare();
    endtask

    task automatic park_and_start(logic [1:0] t, logic [1:0] b);
        oe_hi = 2'b00; sel_tri = t; sel_bin = b;
        step(); step();
        oe_hi = 2'b01;
        #0.1;
        check(clk_out === 1'b1, "R6 restart level", int'(clk_out), 1);
    endtask

    task automatic measure(logic [1:0] t, logic [1:0] b, int n, string tag);
        int hi = 0;
        int lo = 0;
        park_and_start(t, b);
        for (int i = 0; i < 80; i++) begin step(); if (clk_out) hi++; else break; end
        lo = 1;
        for (int i = 0; i < 80; i++) begin step(); if (!clk_out) lo++; else break; end
        check(hi == n / 2, tag, hi, n / 2);
        check(lo == n / 2, tag, lo, n / 2);
    endtask

    initial begin
        #(200000 * 4);
        n_errors++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int hi;
        int lo;
        void'($urandom(32'h5eed1234));
        // R10: reset holds output HIGH across both clock levels
        @(posedge clk_in); #1;
        check(clk_out === 1'b1, "R10 reset high clk", int'(clk_out), 1);
        @(negedge clk_in); #1;
        check(clk_out === 1'b1, "R10 reset low clk", int'(clk_out), 1);
        sel_tri = 2'b01;
        rst_n = 1'b1;
        #0.1;
        check(clk_out === 1'b1, "R10 after release", int'(clk_out), 1);
        step();

        // R1 / R2 / R3 ratio decode
        measure(2'b01, 2'b00, 2,  "R1 div2");
        measure(2'b00, 2'b00, 4,  "R1 div4");
        measure(2'b00, 2'b11, 4,  "R3 bin floating div4");
        measure(2'b10, 2'b01, 8,  "R2 div8");
        measure(2'b01, 2'b01, 16, "R2 div16");
        measure(2'b00, 2'b01, 32, "R2 div32");
        measure(2'b11, 2'b01, 8,  "R3 tri code11 div8");
        measure(2'b01, 2'b10, 2,  "R3 bin floating div2");

        // R9 bypass: output tracks input clock
        park_and_start(2'b11, 2'b10);
        step(); step();
        @(posedge clk_in); model_edge(); #1;
        check(clk_out === 1'b1, "R9 bypass high", int'(clk_out), 1);
        @(negedge clk_in); #1;
        check(clk_out === 1'b0, "R9 bypass low", int'(clk_out), 0);

        // R4 / R5 enable codes
        oe_lo = 2'b01; #0.1;
        check(clk_out_en === 1'b0, "R4 low-enable driven high", int'(clk_out_en), 0);
        check(clk_out === 1'b1, "R6 parked high", int'(clk_out), 1);
        oe_lo = 2'b10; #0.1;
        check(clk_out_en === 1'b1, "R4 low-enable floating", int'(clk_out_en), 1);
        oe_hi = 2'b00; #0.1;
        check(clk_out_en === 1'b0, "R5 high-enable driven low", int'(clk_out_en), 0);
        oe_hi = 2'b11; #0.1;
        check(clk_out_en === 1'b1, "R5 high-enable floating", int'(clk_out_en), 1);
        oe_lo = 2'b00; oe_hi = 2'b01;
        step();

        // R8: switch div8 -> div32 two cycles into a HIGH phase
        park_and_start(2'b10, 2'b01);
        step(); step();
        sel_tri = 2'b00;
        hi = 2;
        for (int i = 0; i < 80; i++) begin step(); if (clk_out) hi++; else break; end
        check(hi == 4, "R8 old high kept", hi, 4);
        lo = 1;
        for (int i = 0; i < 80; i++) begin step(); if (!clk_out) lo++; else break; end
        check(lo == 4, "R8 old low kept", lo, 4);
        hi = 1;
        for (int i = 0; i < 80; i++) begin step(); if (clk_out) hi++; else break; end
        check(hi == 16, "R8 new ratio applied", hi, 16);

        // R6: disable in the middle of a LOW phase, restart full HIGH
        park_and_start(2'b01, 2'b01);
        for (int i = 0; i < 11; i++) step();
        oe_lo = 2'b01;
        step(); step(); step();
        oe_lo = 2'b00;
        hi = 0;
        for (int i = 0; i < 80; i++) begin step(); if (clk_out) hi++; else break; end
        check(hi == 8, "R6 full high after restart", hi, 8);

        // random mix checked by the model every cycle
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom % 16;
            case (r)
                0, 1: sel_tri = 2'($urandom);
                2:    sel_bin = 2'($urandom);
                3:    oe_lo   = 2'($urandom);
                4:    oe_hi   = 2'($urandom);
                5:    begin oe_lo = 2'b00; oe_hi = 2'b01; end
                default: ;
            endcase
            step();
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule